// File: doc/BRIEF.md
# Dual-Bank Register File with Exchange

This block is the register storage of an 8-bit processor core. It keeps two copies, a main one and an alternate one, of the accumulator, the flag byte and six general-purpose byte registers. Two independent exchange strobes choose which copy the datapath sees. One strobe flips the accumulator/flag pair. The other flips all six general-purpose registers together. Beside the banked storage sit two 16-bit index registers, a 16-bit stack pointer, a 16-bit program counter, an 8-bit interrupt-vector byte and an 8-bit refresh counter. None of these is banked.

The datapath reads through two independent combinational ports and writes through one port. Each port accesses either a single byte or a 16-bit pair. Pair accesses always act on the bank that is currently visible, so the physical storage behind a pair depends on the bank selects. An opcode-fetch strobe advances the refresh counter.

Top module: `xbank_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and makes both bank selects point at the main copy.
- R2: A byte access (wide=0) uses the select code 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=A, 7=F, 8=interrupt vector, 9=refresh counter. A byte read returns the value in bits 7:0 with bits 15:8 zero. Codes 10 to 15 read zero and write nothing.
- R3: A pair access (wide=1) uses the select code 0=BC, 1=DE, 2=HL, 3=AF, 4=IX, 5=IY, 6=SP, 7=PC, with the first-named register in bits 15:8. A pair write updates both bytes in the same cycle. Pair codes 8 to 15 read zero and write nothing.
- R4: The accumulator exchange strobe toggles which copy of A and F is visible. The general-purpose registers are left as they are.
- R5: The general-purpose exchange strobe toggles which copy of B, C, D, E, H and L is visible, all six at once. A and F are left as they are.
- R6: The two bank selects are independent. Both strobes may be given in the same cycle, and each then toggles its own select.
- R7: A write given in the same cycle as an exchange lands in the copy that was visible before that cycle. The exchange takes effect from the next cycle.
- R8: Exchanges never change IX, IY, SP, PC or the interrupt-vector byte.
- R9: Each cycle with the fetch strobe high adds one to bits 6:0 of the refresh counter, wrapping from 127 to 0, and keeps bit 7 unchanged.
- R10: When the refresh counter is written in the same cycle as a fetch strobe, the written value is stored and the increment is dropped.
- R11: Reads are combinational. A write becomes visible on the cycle after the clock edge that takes it. The two read ports work independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_wide | input | 1 | Write width: 1 = pair, 0 = byte |
| wr_sel | input | 4 | Write select code |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| xchg_af | input | 1 | Toggle the visible accumulator/flag copy |
| xchg_gp | input | 1 | Toggle the visible general-purpose copy |
| fetch_stb | input | 1 | Opcode-fetch strobe that advances the refresh counter |
| rd0_wide | input | 1 | Read port 0 width select |
| rd0_sel | input | 4 | Read port 0 select code |
| rd0_data | output | 16 | Read port 0 data |
| rd1_wide | input | 1 | Read port 1 width select |
| rd1_sel | input | 4 | Read port 1 select code |
| rd1_data | output | 16 | Read port 1 data |

## Verification
A bank select in the wrong state shows on the very next read of AF or of any general-purpose pair. The read returns the other copy's contents, which the bench makes differ from the expected copy before each such read. A write that lands in the wrong copy stays hidden until the next exchange, so the bench follows each exchange with a read of the pair that was written just before it. A wrong refresh increment appears on the next byte read of code 9, one cycle after the fetch. The counter is driven through its bit-7 boundary so that a carry into bit 7 is caught.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int SEL_W     = 4;
    localparam int NUM_SLOTS = 8;
    localparam int NUM_BANKS = 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int REFRESH_W = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef byte_t [NUM_SLOTS-1:0] slot_vec_t;

    // Byte select codes; slots 0..7 are banked storage.
    typedef enum logic [SEL_W-1:0] {
        BC_B  = 4'd0, BC_C = 4'd1, BC_D = 4'd2, BC_E = 4'd3,
        BC_H  = 4'd4, BC_L = 4'd5, BC_A = 4'd6, BC_F = 4'd7,
        BC_IV = 4'd8, BC_RF = 4'd9
    } byte_code_e;

    // Pair select codes; codes 0..3 map to slot pairs {2k, 2k+1}.
    typedef enum logic [SEL_W-1:0] {
        PC_BC = 4'd0, PC_DE = 4'd1, PC_HL = 4'd2, PC_AF = 4'd3,
        PC_IX = 4'd4, PC_IY = 4'd5, PC_SP = 4'd6, PC_PC = 4'd7
    } pair_code_e;

    localparam int FIRST_AF_SLOT = int'(BC_A);

    typedef struct packed {
        logic              en;
        logic              wide;
        logic [SEL_W-1:0]  sel;
        word_t             data;
    } wr_req_t;

    typedef struct packed {
        word_t ix;
        word_t iy;
        word_t sp;
        word_t pc;
        byte_t iv;
        byte_t rf;
    } spec_view_t;

    // Does a write request touch banked slot s?
    function automatic logic slot_hit(input int s, input wr_req_t w);
        logic hit;
        if (!w.en)
            hit = 1'b0;
        else if (w.wide)
            hit = (w.sel == SEL_W'(s >> 1));
        else
            hit = (w.sel == SEL_W'(s));
        return hit;
    endfunction

    // Byte a write request delivers to banked slot s.
    function automatic byte_t slot_wdata(input int s, input wr_req_t w);
        byte_t d;
        if (w.wide && ((s % 2) == 0))
            d = w.data[WORD_W-1:BYTE_W];
        else
            d = w.data[BYTE_W-1:0];
        return d;
    endfunction

    function automatic logic is_write(input wr_req_t w, input logic wide,
                                      input logic [SEL_W-1:0] code);
        return w.en && (w.wide == wide) && (w.sel == code);
    endfunction

    // Combinational read mux for one port.
    function automatic word_t read_word(input slot_vec_t slots,
                                        input spec_view_t sp,
                                        input logic wide,
                                        input logic [SEL_W-1:0] sel);
        word_t r;
        r = '0;
        if (wide) begin
            case (sel)
                PC_BC, PC_DE, PC_HL, PC_AF:
                    r = {slots[{sel[1:0], 1'b0}], slots[{sel[1:0], 1'b1}]};
                PC_IX:   r = sp.ix;
                PC_IY:   r = sp.iy;
                PC_SP:   r = sp.sp;
                PC_PC:   r = sp.pc;
                default: r = '0;
            endcase
        end else begin
            if (sel < SEL_W'(NUM_SLOTS))
                r = {{BYTE_W{1'b0}}, slots[sel[SLOT_W-1:0]]};
            else if (sel == BC_IV)
                r = {{BYTE_W{1'b0}}, sp.iv};
            else if (sel == BC_RF)
                r = {{BYTE_W{1'b0}}, sp.rf};
            else
                r = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/xbr_bank_store.sv
module xbr_bank_store
    import xbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_req_t   wr,
    input  logic      xchg_af,
    input  logic      xchg_gp,
    output slot_vec_t vis
);

    logic sel_af;
    logic sel_gp;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_af <= 1'b0;
            sel_gp <= 1'b0;
        end else begin
            if (xchg_af) sel_af <= ~sel_af;
            if (xchg_gp) sel_gp <= ~sel_gp;
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam bit IS_AF = (s >= FIRST_AF_SLOT);
        logic  use_alt;
        logic  hit;
        byte_t wd;
        byte_t q [NUM_BANKS];

        assign use_alt = IS_AF ? sel_af : sel_gp;
        assign hit     = slot_hit(s, wr);
        assign wd      = slot_wdata(s, wr);

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int b = 0; b < NUM_BANKS; b++) q[b] <= '0;
            end else if (hit) begin
                q[use_alt] <= wd;
            end
        end

        assign vis[s] = q[use_alt];
    end

    // R1: reset returns both selects to the main copy
    a_r1_main_after_reset: assert property (@(posedge clk)
        rst |=> (!sel_af && !sel_gp));

    // R4: accumulator exchange toggles its select
    a_r4_af_toggle: assert property (@(posedge clk) disable iff (rst)
        xchg_af |=> (sel_af != $past(sel_af)));

    // R5: general-purpose exchange toggles its select
    a_r5_gp_toggle: assert property (@(posedge clk) disable iff (rst)
        xchg_gp |=> (sel_gp != $past(sel_gp)));

    // R6: a select holds when its own strobe is absent
    a_r6_independent: assert property (@(posedge clk) disable iff (rst)
        (xchg_gp && !xchg_af) |=> $stable(sel_af));

    // R3: a BC pair write shows both bytes next cycle
    a_r3_pair_write: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.wide && wr.sel == PC_BC && !xchg_gp) |=>
        (vis[BC_B] == $past(wr.data[WORD_W-1:BYTE_W]) &&
         vis[BC_C] == $past(wr.data[BYTE_W-1:0])));

endmodule

// File: rtl/xbr_special_regs.sv
module xbr_special_regs
    import xbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  logic       fetch_stb,
    output spec_view_t view
);

    word_t ix_q, iy_q, sp_q, pc_q;
    byte_t iv_q, rf_q;
    logic  rf_wr;

    assign rf_wr = is_write(wr, 1'b0, BC_RF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ix_q <= '0;
            iy_q <= '0;
            sp_q <= '0;
            pc_q <= '0;
        end else begin
            if (is_write(wr, 1'b1, PC_IX)) ix_q <= wr.data;
            if (is_write(wr, 1'b1, PC_IY)) iy_q <= wr.data;
            if (is_write(wr, 1'b1, PC_SP)) sp_q <= wr.data;
            if (is_write(wr, 1'b1, PC_PC)) pc_q <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            iv_q <= '0;
        else if (is_write(wr, 1'b0, BC_IV))
            iv_q <= wr.data[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rf_q <= '0;
        else if (rf_wr)
            rf_q <= wr.data[BYTE_W-1:0];
        else if (fetch_stb)
            rf_q <= {rf_q[BYTE_W-1], rf_q[REFRESH_W-1:0] + REFRESH_W'(1)};
    end

    assign view = '{ix: ix_q, iy: iy_q, sp: sp_q, pc: pc_q, iv: iv_q, rf: rf_q};

    // R8: without a write the unbanked words and vector byte hold
    a_r8_unbanked_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> ($stable(ix_q) && $stable(iy_q) && $stable(sp_q) &&
                    $stable(pc_q) && $stable(iv_q)));

    // R9: fetch increments low seven bits and keeps the top bit
    a_r9_refresh_step: assert property (@(posedge clk) disable iff (rst)
        (fetch_stb && !rf_wr) |=>
        (rf_q[REFRESH_W-1:0] == $past(rf_q[REFRESH_W-1:0]) + REFRESH_W'(1) &&
         rf_q[BYTE_W-1] == $past(rf_q[BYTE_W-1])));

    // R10: a write to the refresh counter beats the fetch increment
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> (rf_q == $past(wr.data[BYTE_W-1:0])));

endmodule

// File: rtl/xbr_read_port.sv
module xbr_read_port
    import xbr_pkg::*;
(
    input  slot_vec_t        slots,
    input  spec_view_t       spec,
    input  logic             wide,
    input  logic [SEL_W-1:0] sel,
    output word_t            data
);

    assign data = read_word(slots, spec, wide, sel);

    // R2: a byte read never drives the upper byte
    always_comb begin
        a_r2_byte_upper_zero: assert (wide || data[WORD_W-1:BYTE_W] == '0);
    end

endmodule

// File: rtl/xbank_regfile.sv
module xbank_regfile
    import xbr_pkg::*;
#(
    parameter int NUM_RD = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_wide,
    input  logic [3:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic        xchg_af,
    input  logic        xchg_gp,
    input  logic        fetch_stb,
    input  logic        rd0_wide,
    input  logic [3:0]  rd0_sel,
    output logic [15:0] rd0_data,
    input  logic        rd1_wide,
    input  logic [3:0]  rd1_sel,
    output logic [15:0] rd1_data
);

    wr_req_t          wr;
    slot_vec_t        slots;
    spec_view_t       spec;
    logic             rd_wide [NUM_RD];
    logic [SEL_W-1:0] rd_sel  [NUM_RD];
    word_t            rd_data [NUM_RD];

    assign wr = '{en: wr_en, wide: wr_wide, sel: wr_sel, data: wr_data};

    xbr_bank_store u_banks (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .xchg_af (xchg_af),
        .xchg_gp (xchg_gp),
        .vis     (slots)
    );

    xbr_special_regs u_special (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .fetch_stb (fetch_stb),
        .view      (spec)
    );

    assign rd_wide[0] = rd0_wide;
    assign rd_sel[0]  = rd0_sel;
    assign rd_wide[1] = rd1_wide;
    assign rd_sel[1]  = rd1_sel;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        xbr_read_port u_port (
            .slots (slots),
            .spec  (spec),
            .wide  (rd_wide[p]),
            .sel   (rd_sel[p]),
            .data  (rd_data[p])
        );
    end

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];

endmodule

// File: tb/xbank_regfile_test.sv
module xbank_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_wide, xchg_af, xchg_gp, fetch_stb;
    logic [3:0]  wr_sel;
    logic [15:0] wr_data;
    logic        rd0_wide, rd1_wide;
    logic [3:0]  rd0_sel, rd1_sel;
    logic [15:0] rd0_data, rd1_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbank_regfile uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .xchg_af(xchg_af), .xchg_gp(xchg_gp), .fetch_stb(fetch_stb),
        .rd0_wide(rd0_wide), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
        .rd1_wide(rd1_wide), .rd1_sel(rd1_sel), .rd1_data(rd1_data)
    );

    typedef struct packed {
        logic        we;
        logic        ww;
        logic [3:0]  ws;
        logic [15:0] wd;
        logic        xa;
        logic        xg;
        logic        fe;
        logic        rw;
        logic [3:0]  rs;
        logic [15:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1,1,4'd0,16'h1234,0,0,0,1,4'd0,16'h1234,4'd3},  // R3 BC pair write
        '{1,0,4'd1,16'h0056,0,0,0,1,4'd0,16'h1256,4'd2},  // R2 byte C
        '{1,1,4'd2,16'hABCD,0,0,0,0,4'd4,16'h00AB,4'd3},  // R3 HL, read H
        '{0,0,4'd0,16'h0000,0,1,0,1,4'd0,16'h0000,4'd5},  // R5 alt GP empty
        '{1,1,4'd0,16'h9988,0,0,0,0,4'd0,16'h0099,4'd5},  // R5 alt B
        '{1,0,4'd6,16'h0011,0,0,0,1,4'd3,16'h1100,4'd3},  // R3 A high in AF
        '{0,0,4'd0,16'h0000,1,0,0,1,4'd3,16'h0000,4'd4},  // R4 alt AF
        '{1,0,4'd7,16'h0022,0,0,0,1,4'd3,16'h0022,4'd4},  // R4 alt F
        '{0,0,4'd0,16'h0000,0,1,0,1,4'd0,16'h1256,4'd5},  // R5 back to main GP
        '{0,0,4'd0,16'h0000,0,0,0,1,4'd3,16'h0022,4'd6},  // R6 AF still alt
        '{0,0,4'd0,16'h0000,1,0,0,1,4'd3,16'h1100,4'd4},  // R4 main AF
        '{1,1,4'd4,16'hCAFE,0,0,0,1,4'd4,16'hCAFE,4'd3},  // R3 IX
        '{0,0,4'd0,16'h0000,1,1,0,1,4'd4,16'hCAFE,4'd8},  // R8 IX after both
        '{0,0,4'd0,16'h0000,0,0,0,1,4'd0,16'h9988,4'd6},  // R6 GP alt
        '{0,0,4'd0,16'h0000,0,0,0,1,4'd3,16'h0022,4'd6},  // R6 AF alt
        '{1,0,4'd8,16'h005A,0,0,0,0,4'd8,16'h005A,4'd2},  // R2 vector byte
        '{1,0,4'd9,16'h00FF,0,0,0,0,4'd9,16'h00FF,4'd2},  // R2 refresh byte
        '{0,0,4'd0,16'h0000,0,0,1,0,4'd9,16'h0080,4'd9},  // R9 wrap keeps bit7
        '{0,0,4'd0,16'h0000,0,0,1,0,4'd9,16'h0081,4'd9},  // R9 step
        '{1,1,4'd6,16'hFFFE,0,0,0,1,4'd6,16'hFFFE,4'd3},  // R3 SP
        '{1,1,4'd7,16'h0100,0,0,1,0,4'd9,16'h0082,4'd9},  // R9 fetch with PC write
        '{0,0,4'd0,16'h0000,0,0,0,1,4'd7,16'h0100,4'd3},  // R3 PC
        '{1,1,4'd2,16'h4321,0,1,0,1,4'd2,16'hABCD,4'd7},  // R7 write+exchange
        '{0,0,4'd0,16'h0000,0,1,0,1,4'd2,16'h4321,4'd7},  // R7 landed in old copy
        '{1,0,4'd9,16'h0010,0,0,1,0,4'd9,16'h0010,4'd10}, // R10 write wins
        '{0,0,4'd0,16'h0000,0,0,0,0,4'd10,16'h0000,4'd2}, // R2 unused byte code
        '{1,1,4'd1,16'hBEEF,0,0,0,0,4'd3,16'h00EF,4'd3},  // R3 DE, read E
        '{0,0,4'd0,16'h0000,1,1,0,0,4'd8,16'h005A,4'd8},  // R8 vector byte
        '{0,0,4'd0,16'h0000,0,0,0,1,4'd6,16'hFFFE,4'd8},  // R8 SP
        '{1,1,4'd9,16'h7777,0,0,0,1,4'd9,16'h0000,4'd3}   // R3 unused pair code
    };

    task automatic chk(input int rq, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_wide = 0; wr_sel = 0; wr_data = 0;
        xchg_af = 0; xchg_gp = 0; fetch_stb = 0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        wr_en = v.we; wr_wide = v.ww; wr_sel = v.ws; wr_data = v.wd;
        xchg_af = v.xa; xchg_gp = v.xg; fetch_stb = v.fe;
        rd0_wide = v.rw; rd0_sel = v.rs;
        @(posedge clk);
        #1 idle();
        #1 chk(int'(v.rq), "vector", rd0_data, v.exp);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        idle();
        rd0_wide = 0; rd0_sel = 0; rd1_wide = 0; rd1_sel = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: every byte and pair reads zero after reset
        for (int c = 0; c < 10; c++) begin
            rd0_wide = 0; rd0_sel = 4'(c);
            rd1_wide = 1; rd1_sel = 4'(c % 8);
            #1;
            chk(1, "reset byte", rd0_data, 16'h0000);
            chk(1, "reset pair", rd1_data, 16'h0000);
        end

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R11: two ports read independently
        @(negedge clk);
        rd0_wide = 1; rd0_sel = 4'd7;
        rd1_wide = 1; rd1_sel = 4'd4;
        #1;
        chk(11, "port0 PC", rd0_data, 16'h0100);
        chk(11, "port1 IX", rd1_data, 16'hCAFE);

        // R11: write not visible before the edge, visible after it
        @(negedge clk);
        wr_en = 1; wr_wide = 1; wr_sel = 4'd5; wr_data = 16'h7777;
        rd1_wide = 1; rd1_sel = 4'd5;
        #1 chk(11, "IY before edge", rd1_data, 16'h0000);
        @(posedge clk);
        #1 idle();
        #1 chk(11, "IY after edge", rd1_data, 16'h7777);

        // R1: reset mid-run clears data and bank selects
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        rd0_wide = 1; rd0_sel = 4'd3;
        rd1_wide = 1; rd1_sel = 4'd5;
        #1;
        chk(1, "AF after reset", rd0_data, 16'h0000);
        chk(1, "IY after reset", rd1_data, 16'h0000);
        // write main A, toggle: alt must read zero, proving select was main
        apply('{1,0,4'd6,16'h0044,0,0,0,1,4'd3,16'h4400,4'd1});
        apply('{0,0,4'd0,16'h0000,1,0,0,1,4'd3,16'h0000,4'd1});
        // R9: refresh from 0x7F wraps low bits, bit7 stays clear
        apply('{1,0,4'd9,16'h007F,0,0,0,0,4'd9,16'h007F,4'd9});
        apply('{0,0,4'd0,16'h0000,0,0,1,0,4'd9,16'h0000,4'd9});

        done = 1'b1;
        finish_run();
    end

endmodule